// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces the scan timing for one display channel. A horizontal pixel counter and a vertical line counter walk the raster. Six 32-bit timing words set the shape of the frame. Each word carries two 16-bit fields, and each field holds its value minus one. The block drives data-enable, blanking, horizontal and vertical sync with polarities the user can choose, the current pixel position, a one-cycle start-of-frame strobe and a one-cycle strobe on the first line of vertical blanking. It also gives two packed size words for downstream source and plane logic.

In fixed-panel mode the six words come from a built-in encoder and the external words are ignored. For each axis the encoder takes four panel figures: active size, blanking length, sync offset and sync width. Whichever source is selected passes into a shadow copy only at a frame boundary. Configuration can therefore change at any time and no frame mixes old and new timing.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held, and in the first cycle after its release, the outputs are: `pix_x`=0, `pix_y`=0, `de`=0, `blank`=1, `hsync`=0, `vsync`=0, `sof`=0, `vbs`=0, `src_size`=0, `plane_size`=0.
- R2: Each timing word has a low field in bits 15:0 and a high field in bits 31:16. `pix_x` counts up by one each cycle from 0 to the high field of the horizontal total word, then returns to 0.
- R3: `pix_y` steps by one only in a cycle where `pix_x` returns to 0. After the line whose number equals the high field of the vertical total word, it returns to 0.
- R4: `de` is 1 exactly when `pix_x` ≤ the low field of the horizontal total word and `pix_y` ≤ the low field of the vertical total word.
- R5: `blank` is 1 when, on either axis, the position is greater than the low field and at most the high field of that axis's blank word.
- R6: The raw horizontal sync is active when `pix_x` is greater than the low field and at most the high field of the horizontal sync word. Vertical sync uses `pix_y` and the vertical sync word in the same way.
- R7: When `hs_pol`=1, `hsync` follows the raw horizontal sync. When `hs_pol`=0, `hsync` is its inverse. `vs_pol` does the same for `vsync`, independently of `hs_pol`.
- R8: `sof` is 1 for the single cycle in which the position is (0,0).
- R9: `vbs` is 1 for one cycle, at `pix_x`=0 on the line whose number equals the vertical blank word's low field plus one.
- R10: Changes to the timing words, polarities, mode select or panel figures take effect only from the next (0,0) cycle. The rest of the current frame keeps the old timing.
- R11: When `panel_mode`=1, each axis uses words built from its panel figures: active A, blanking B, offset O, width W. The total and blank words are both {A+B−1, A−1}. The sync word is {A+O+W−1, A+O−1}, written as {high, low}.
- R12: `src_size` carries (width−1) in bits 31:16 and (height−1) in bits 15:0. `plane_size` carries height−1 in bits 31:16 and width−1 in bits 15:0. Width−1 and height−1 are the low fields of the active total words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| panel_mode | input | 1 | 1 selects timing built from panel figures |
| tm_htot | input | 32 | Horizontal {total−1, active−1} |
| tm_hblank | input | 32 | Horizontal blank {end−1, start−1} |
| tm_hsync | input | 32 | Horizontal sync {end−1, start−1} |
| tm_vtot | input | 32 | Vertical {total−1, active−1} |
| tm_vblank | input | 32 | Vertical blank {end−1, start−1} |
| tm_vsync | input | 32 | Vertical sync {end−1, start−1} |
| pnl_hact | input | 16 | Panel horizontal active pixels |
| pnl_hblk | input | 16 | Panel horizontal blanking length |
| pnl_hsoff | input | 16 | Panel horizontal sync offset |
| pnl_hswid | input | 16 | Panel horizontal sync width |
| pnl_vact | input | 16 | Panel vertical active lines |
| pnl_vblk | input | 16 | Panel vertical blanking length |
| pnl_vsoff | input | 16 | Panel vertical sync offset |
| pnl_vswid | input | 16 | Panel vertical sync width |
| hs_pol | input | 1 | 1 = active-high horizontal sync |
| vs_pol | input | 1 | 1 = active-high vertical sync |
| pix_x | output | 16 | Current pixel column |
| pix_y | output | 16 | Current line |
| de | output | 1 | Active video |
| blank | output | 1 | Blanking interval |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| sof | output | 1 | Start-of-frame strobe |
| vbs | output | 1 | Vertical blanking start strobe |
| src_size | output | 32 | {width−1, height−1} |
| plane_size | output | 32 | {height−1, width−1} |

## Verification
The assertions assume that inputs change only away from the clock edge. They also assume that a programmed vertical blank window is not empty, meaning its start field is below its end field. Without that, the blanking-start strobe could fall on a line that is not blanked. The stimulus uses only windows whose start field is below the end field and whose end lies inside the total. It changes inputs on the falling edge, including in the middle of a frame, so that the frame-boundary update of R10 is exercised.

// File: rtl/tg_pkg.sv
package tg_pkg;
    localparam int TG_FW   = 16;
    localparam int TG_AXES = 2;
    localparam int TG_NREG = 3;
    // axis index
    localparam int AX_H = 0;
    localparam int AX_V = 1;
    // word index within one axis
    localparam int RG_TOT = 0;
    localparam int RG_BLK = 1;
    localparam int RG_SYN = 2;
endpackage

// File: rtl/tg_panel_enc.sv
module tg_panel_enc #(
    parameter int FW = 16
) (
    input  logic [FW-1:0]   act,
    input  logic [FW-1:0]   blk,
    input  logic [FW-1:0]   soff,
    input  logic [FW-1:0]   swid,
    output logic [2*FW-1:0] w_tot,
    output logic [2*FW-1:0] w_blk,
    output logic [2*FW-1:0] w_syn
);
    localparam logic [FW-1:0] ONE = FW'(1);

    logic [FW-1:0] act_m1;
    logic [FW-1:0] span_m1;
    logic [FW-1:0] ss_m1;
    logic [FW-1:0] se_m1;

    always_comb begin
        act_m1  = act - ONE;
        span_m1 = act + blk - ONE;
        ss_m1   = act + soff - ONE;
        se_m1   = act + soff + swid - ONE;
        w_tot   = {span_m1, act_m1};
        w_blk   = {span_m1, act_m1};
        w_syn   = {se_m1, ss_m1};
    end
endmodule

// File: rtl/tg_axis_dec.sv
module tg_axis_dec #(
    parameter int FW = 16
) (
    input  logic [FW-1:0]   pos,
    input  logic [2*FW-1:0] w_tot,
    input  logic [2*FW-1:0] w_blk,
    input  logic [2*FW-1:0] w_syn,
    output logic            in_act,
    output logic            in_blk,
    output logic            in_syn,
    output logic            at_last,
    output logic [FW-1:0]   size_m1
);
    always_comb begin
        size_m1 = w_tot[FW-1:0];
        in_act  = (pos <= w_tot[FW-1:0]);
        at_last = (pos == w_tot[2*FW-1:FW]);
        in_blk  = (pos > w_blk[FW-1:0]) && (pos <= w_blk[2*FW-1:FW]);
        in_syn  = (pos > w_syn[FW-1:0]) && (pos <= w_syn[2*FW-1:FW]);
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import tg_pkg::*;
#(
    parameter int FW = TG_FW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            panel_mode,
    input  logic [2*FW-1:0] tm_htot,
    input  logic [2*FW-1:0] tm_hblank,
    input  logic [2*FW-1:0] tm_hsync,
    input  logic [2*FW-1:0] tm_vtot,
    input  logic [2*FW-1:0] tm_vblank,
    input  logic [2*FW-1:0] tm_vsync,
    input  logic [FW-1:0]   pnl_hact,
    input  logic [FW-1:0]   pnl_hblk,
    input  logic [FW-1:0]   pnl_hsoff,
    input  logic [FW-1:0]   pnl_hswid,
    input  logic [FW-1:0]   pnl_vact,
    input  logic [FW-1:0]   pnl_vblk,
    input  logic [FW-1:0]   pnl_vsoff,
    input  logic [FW-1:0]   pnl_vswid,
    input  logic            hs_pol,
    input  logic            vs_pol,
    output logic [FW-1:0]   pix_x,
    output logic [FW-1:0]   pix_y,
    output logic            de,
    output logic            blank,
    output logic            hsync,
    output logic            vsync,
    output logic            sof,
    output logic            vbs,
    output logic [2*FW-1:0] src_size,
    output logic [2*FW-1:0] plane_size
);
    localparam int RW  = 2 * FW;
    localparam int NSH = TG_AXES * TG_NREG;
    localparam logic [FW-1:0] ONE  = FW'(1);
    localparam logic [FW:0]   ONEX = (FW + 1)'(1);

    typedef struct packed {
        logic                   run;
        logic [FW-1:0]          h;
        logic [FW-1:0]          v;
        logic [NSH-1:0][RW-1:0] sh;
        logic                   hp;
        logic                   vp;
    } st_t;

    localparam st_t ST_RST = '{run: 1'b0, h: '0, v: '0, sh: '0, hp: 1'b1, vp: 1'b1};

    st_t s_q, s_d;

    // ---------------- configuration source selection ----------------
    logic [TG_AXES-1:0][FW-1:0] pa_act, pa_blk, pa_soff, pa_swid;
    logic [NSH-1:0][RW-1:0]     w_dir, w_pan, w_eff;

    assign pa_act  = {pnl_vact,  pnl_hact};
    assign pa_blk  = {pnl_vblk,  pnl_hblk};
    assign pa_soff = {pnl_vsoff, pnl_hsoff};
    assign pa_swid = {pnl_vswid, pnl_hswid};
    assign w_dir   = {tm_vsync, tm_vblank, tm_vtot, tm_hsync, tm_hblank, tm_htot};

    // ---------------- per-axis encoders and decoders ----------------
    logic [TG_AXES-1:0][FW-1:0] ax_pos;
    logic [TG_AXES-1:0][FW-1:0] ax_size;
    logic [TG_AXES-1:0]         ax_act, ax_blk, ax_syn, ax_last;

    assign ax_pos = {s_q.v, s_q.h};

    for (genvar a = 0; a < TG_AXES; a++) begin : g_axis
        tg_panel_enc #(.FW(FW)) u_enc (
            .act   (pa_act[a]),
            .blk   (pa_blk[a]),
            .soff  (pa_soff[a]),
            .swid  (pa_swid[a]),
            .w_tot (w_pan[a*TG_NREG+RG_TOT]),
            .w_blk (w_pan[a*TG_NREG+RG_BLK]),
            .w_syn (w_pan[a*TG_NREG+RG_SYN])
        );

        for (genvar r = 0; r < TG_NREG; r++) begin : g_sel
            assign w_eff[a*TG_NREG+r] = panel_mode ? w_pan[a*TG_NREG+r]
                                                   : w_dir[a*TG_NREG+r];
        end

        tg_axis_dec #(.FW(FW)) u_dec (
            .pos     (ax_pos[a]),
            .w_tot   (s_q.sh[a*TG_NREG+RG_TOT]),
            .w_blk   (s_q.sh[a*TG_NREG+RG_BLK]),
            .w_syn   (s_q.sh[a*TG_NREG+RG_SYN]),
            .in_act  (ax_act[a]),
            .in_blk  (ax_blk[a]),
            .in_syn  (ax_syn[a]),
            .at_last (ax_last[a]),
            .size_m1 (ax_size[a])
        );
    end

    // ---------------- next-state ----------------
    always_comb begin
        s_d = s_q;
        if (!s_q.run) begin
            s_d.run = 1'b1;
            s_d.h   = '0;
            s_d.v   = '0;
            s_d.sh  = w_eff;
            s_d.hp  = hs_pol;
            s_d.vp  = vs_pol;
        end else if (ax_last[AX_H]) begin
            s_d.h = '0;
            if (ax_last[AX_V]) begin
                s_d.v  = '0;
                s_d.sh = w_eff;
                s_d.hp = hs_pol;
                s_d.vp = vs_pol;
            end else begin
                s_d.v = s_q.v + ONE;
            end
        end else begin
            s_d.h = s_q.h + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= ST_RST;
        else        s_q <= s_d;
    end

    // ---------------- outputs ----------------
    logic [FW:0]            vb_line;
    logic                   at_origin;
    logic [NSH*RW-1:0]      sh_flat;

    assign sh_flat   = s_q.sh;
    assign vb_line   = {1'b0, s_q.sh[AX_V*TG_NREG+RG_BLK][FW-1:0]} + ONEX;
    assign at_origin = (s_q.h == '0) && (s_q.v == '0);

    always_comb begin
        pix_x      = s_q.h;
        pix_y      = s_q.v;
        de         = s_q.run && ax_act[AX_H] && ax_act[AX_V];
        blank      = !s_q.run || ax_blk[AX_H] || ax_blk[AX_V];
        hsync      = ~((s_q.run && ax_syn[AX_H]) ^ s_q.hp);
        vsync      = ~((s_q.run && ax_syn[AX_V]) ^ s_q.vp);
        sof        = s_q.run && at_origin;
        vbs        = s_q.run && (s_q.h == '0) && ({1'b0, s_q.v} == vb_line);
        src_size   = {ax_size[AX_H], ax_size[AX_V]};
        plane_size = {ax_size[AX_V], ax_size[AX_H]};
    end
endmodule

// File: rtl/tg_chk.sv
module tg_chk #(
    parameter int FW = 16,
    parameter int SW = 192
) (
    input logic          clk,
    input logic          rst_n,
    input logic [FW-1:0] pix_x,
    input logic [FW-1:0] pix_y,
    input logic          sof,
    input logic          vbs,
    input logic          blank,
    input logic [SW-1:0] sh_flat
);
    localparam logic [FW-1:0] ONE = FW'(1);

    // R2
    x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x != '0) |-> (pix_x == $past(pix_x) + ONE));

    // R3
    y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x != '0) |-> $stable(pix_y));

    // R8
    sof_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (pix_x == '0 && pix_y == '0));

    // R9
    vbs_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vbs |-> (blank && pix_x == '0));

    // R10
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |-> $stable(sh_flat));
endmodule

bind raster_timing_gen tg_chk #(.FW(FW), .SW(NSH*RW)) u_tg_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_x   (pix_x),
    .pix_y   (pix_y),
    .sof     (sof),
    .vbs     (vbs),
    .blank   (blank),
    .sh_flat (sh_flat)
);

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        panel_mode = 1'b0;
    logic [31:0] tm_htot, tm_hblank, tm_hsync, tm_vtot, tm_vblank, tm_vsync;
    logic [15:0] pnl_hact, pnl_hblk, pnl_hsoff, pnl_hswid;
    logic [15:0] pnl_vact, pnl_vblk, pnl_vsoff, pnl_vswid;
    logic        hs_pol = 1'b1, vs_pol = 1'b1;
    logic [15:0] pix_x, pix_y;
    logic        de, blank, hsync, vsync, sof, vbs;
    logic [31:0] src_size, plane_size;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    raster_timing_gen i_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .panel_mode(panel_mode),
        .tm_htot(tm_htot), .tm_hblank(tm_hblank), .tm_hsync(tm_hsync),
        .tm_vtot(tm_vtot), .tm_vblank(tm_vblank), .tm_vsync(tm_vsync),
        .pnl_hact(pnl_hact), .pnl_hblk(pnl_hblk), .pnl_hsoff(pnl_hsoff), .pnl_hswid(pnl_hswid),
        .pnl_vact(pnl_vact), .pnl_vblk(pnl_vblk), .pnl_vsoff(pnl_vsoff), .pnl_vswid(pnl_vswid),
        .hs_pol(hs_pol), .vs_pol(vs_pol),
        .pix_x(pix_x), .pix_y(pix_y), .de(de), .blank(blank),
        .hsync(hsync), .vsync(vsync), .sof(sof), .vbs(vbs),
        .src_size(src_size), .plane_size(plane_size)
    );

    // ---------------- behavioural reference ----------------
    int  m_h = 0, m_v = 0;
    bit  m_run = 0;
    int  m_w[6] = '{default: 0};
    bit  m_hp = 1, m_vp = 1;

    function automatic int lo(int w); return w & 32'hFFFF; endfunction
    function automatic int hi(int w); return (w >>> 16) & 32'hFFFF; endfunction
    function automatic int pack(int h_f, int l_f); return ((h_f & 32'hFFFF) << 16) | (l_f & 32'hFFFF); endfunction

    task automatic load_cfg();
        if (panel_mode) begin
            int a, b, o, w;
            a = pnl_hact; b = pnl_hblk; o = pnl_hsoff; w = pnl_hswid;
            m_w[0] = pack(a + b - 1, a - 1);
            m_w[1] = pack(a + b - 1, a - 1);
            m_w[2] = pack(a + o + w - 1, a + o - 1);
            a = pnl_vact; b = pnl_vblk; o = pnl_vsoff; w = pnl_vswid;
            m_w[3] = pack(a + b - 1, a - 1);
            m_w[4] = pack(a + b - 1, a - 1);
            m_w[5] = pack(a + o + w - 1, a + o - 1);
        end else begin
            m_w[0] = tm_htot;  m_w[1] = tm_hblank; m_w[2] = tm_hsync;
            m_w[3] = tm_vtot;  m_w[4] = tm_vblank; m_w[5] = tm_vsync;
        end
        m_hp = hs_pol;
        m_vp = vs_pol;
    endtask

    task automatic model_advance();
        if (!m_run) begin
            m_run = 1; m_h = 0; m_v = 0; load_cfg();
        end else if (m_h == hi(m_w[0])) begin
            m_h = 0;
            if (m_v == hi(m_w[3])) begin
                m_v = 0; load_cfg();
            end else m_v++;
        end else m_h++;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h (x=%0d y=%0d)", tag, act, exp, m_h, m_v);
        end
    endtask

    function automatic bit inside_win(int p, int w);
        return (p > lo(w)) && (p <= hi(w));
    endfunction

    task automatic compare();
        bit e_de, e_bl, e_hs, e_vs, e_sof, e_vbs;
        e_de  = m_run && (m_h <= lo(m_w[0])) && (m_v <= lo(m_w[3]));
        e_bl  = !m_run || inside_win(m_h, m_w[1]) || inside_win(m_v, m_w[4]);
        e_hs  = (m_run && inside_win(m_h, m_w[2])) ? m_hp : !m_hp;
        e_vs  = (m_run && inside_win(m_v, m_w[5])) ? m_vp : !m_vp;
        e_sof = m_run && m_h == 0 && m_v == 0;
        e_vbs = m_run && m_h == 0 && m_v == lo(m_w[4]) + 1;
        chk("R2 pix_x", 32'(pix_x), m_h);
        chk("R3 pix_y", 32'(pix_y), m_v);
        chk("R4 de", 32'(de), 32'(e_de));
        chk("R5 blank", 32'(blank), 32'(e_bl));
        chk("R6/R7 hsync", 32'(hsync), 32'(e_hs));
        chk("R6/R7 vsync", 32'(vsync), 32'(e_vs));
        chk("R8 sof", 32'(sof), 32'(e_sof));
        chk("R9 vbs", 32'(vbs), 32'(e_vbs));
        chk("R12 src_size", src_size, pack(lo(m_w[0]), lo(m_w[3])));
        chk("R12 plane_size", plane_size, pack(lo(m_w[3]), lo(m_w[0])));
    endtask

    task automatic step();
        @(posedge clk);
        model_advance();
        @(negedge clk);
        compare();
    endtask

    task automatic run_until_sof(int n);
        int c = 0;
        while (c < n) begin
            step();
            if (sof) c++;
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int maxx, cnt_hs, cnt_de;
        // Config A: 20x10 total, 12x6 active
        tm_htot   = {16'd19, 16'd11};
        tm_hblank = {16'd19, 16'd11};
        tm_hsync  = {16'd16, 16'd13};
        tm_vtot   = {16'd9,  16'd5};
        tm_vblank = {16'd9,  16'd5};
        tm_vsync  = {16'd7,  16'd6};
        pnl_hact = 16'd10; pnl_hblk = 16'd6; pnl_hsoff = 16'd2; pnl_hswid = 16'd3;
        pnl_vact = 16'd4;  pnl_vblk = 16'd3; pnl_vsoff = 16'd1; pnl_vswid = 16'd1;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pix_x", 32'(pix_x), 0);
        chk("R1 pix_y", 32'(pix_y), 0);
        chk("R1 de", 32'(de), 0);
        chk("R1 blank", 32'(blank), 1);
        chk("R1 hsync", 32'(hsync), 0);
        chk("R1 vsync", 32'(vsync), 0);
        chk("R1 sof", 32'(sof), 0);
        chk("R1 vbs", 32'(vbs), 0);
        chk("R1 src_size", src_size, 0);
        chk("R1 plane_size", plane_size, 0);
        rst_n = 1'b1;

        run_until_sof(3);

        // Polarity change plus different blank windows (mid-frame, R7 / R10)
        repeat (37) step();
        hs_pol    = 1'b0;
        tm_hblank = {16'd18, 16'd12};
        tm_vblank = {16'd8,  16'd6};
        run_until_sof(3);

        // R10: shrink the line mid-frame; the rest of the frame keeps the old length
        repeat (50) step();
        tm_htot = {16'd13, 16'd9};
        tm_hblank = {16'd13, 16'd10};
        tm_hsync  = {16'd12, 16'd10};
        vs_pol = 1'b0;
        maxx = 0;
        forever begin
            step();
            if (sof) break;
            if (pix_x > maxx) maxx = pix_x;
        end
        chk("R10 old line length kept", 32'(maxx), 19);
        maxx = pix_x;
        forever begin
            step();
            if (sof) break;
            if (pix_x > maxx) maxx = pix_x;
        end
        chk("R10 new line length applied", 32'(maxx), 13);

        // R11: fixed-panel encoding
        hs_pol = 1'b1;
        repeat (21) step();
        panel_mode = 1'b1;
        run_until_sof(1);
        cnt_hs = hsync ? 1 : 0;
        cnt_de = de ? 1 : 0;
        repeat (15) begin
            step();
            if (hsync) cnt_hs++;
            if (de) cnt_de++;
        end
        chk("R11 hsync width", 32'(cnt_hs), 3);
        chk("R11 active width", 32'(cnt_de), 10);
        step();
        chk("R11 line total", 32'(pix_x), 0);
        run_until_sof(2);
        chk("R11 src_size", src_size, {16'd9, 16'd3});

        // R11: external words are ignored while panel mode is set
        tm_htot = {16'd30, 16'd20};
        run_until_sof(2);
        chk("R11 external ignored", src_size, {16'd9, 16'd3});

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        #(200000 * 5);
        nerr++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule